// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector

This block watches a non-return-to-zero serial stream, one bit per cycle in which the bit enable is high. It raises a loss-of-signal alarm when the stream stops changing level. The alarm is declared quickly, after a long run with no level change. It is released more cautiously: a fixed 128-bit window must show a healthy number of transitions. While the alarm is up, the recovered data handed downstream is held at zero, which marks a failed line for later stages.

A second source can force the alarm. Two external inputs are combined with an XNOR. One of them carries the optics signal-detect flag and the other is tied to select the flag's polarity. An active-low detection enable can switch the transition-based detector off, and the external force still works while it is off. Reset puts the block in the alarm state, so the line has to prove itself before data flows.

Top module: `sig_loss_monitor`

## Requirements
- R1: The alarm is declared when a bit arrives with no transition while the run counter already holds 128 non-transition bits. That is the 129th consecutive bit equal to its predecessor. `los` is high from the next clock on.
- R2: Any transition (a sampled bit different from the previously sampled bit, which is 0 after reset) restarts the run count. 128 equal bits followed by a transition never declare the alarm.
- R3: Windows are 128 sampled bits long and are aligned to the count of enabled bits since reset. At the last bit of a window the internal alarm is cleared when the transitions counted in that window, including the last bit, number 17 or more. 16 transitions do not clear it.
- R4: The transition count restarts at every window boundary. Transitions in two neighbouring windows are never added together.
- R5: `dout` equals the most recently sampled bit while `los` is low, and is 0 while `los` is high.
- R6: When `ext_a` equals `ext_b` (XNOR = 1), `los` is high from the next clock, whatever the transition detector decides, including on a cycle where a window clears the internal alarm.
- R7: While `det_en_n` is 1 the internal alarm is held cleared and cannot be declared. With `ext_a` different from `ext_b`, `los` is then low from the next clock.
- R8: Synchronous active-high `rst` sets `los` to 1 and `dout` to 0, and restarts the run count and the window.
- R9: Cycles with `bit_en` low do not sample `din`. They advance neither the run count nor the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High in a cycle that carries a serial bit |
| din | input | 1 | Serial data in |
| det_en_n | input | 1 | Transition detection enable, active low |
| ext_a | input | 1 | External loss indicator, first XNOR input |
| ext_b | input | 1 | External loss indicator, second XNOR input (polarity select) |
| los | output | 1 | Registered loss-of-signal alarm |
| dout | output | 1 | Last sampled bit, forced to 0 during the alarm |

## Verification
The external force and the window-end clear of the internal alarm can land on the same bit. In that case `los` must stay high for that clock and fall only once the force is released, which shows the clear was taken underneath. The bench provokes this by raising the XNOR condition on the closing bits of a window that carries 20 transitions. A reference model computes `los` and `dout` every cycle, and random segments mix transition densities with flips of the force and the enable. These segments reach the same coincidence many more times.

// File: rtl/sld_pkg.sv
package sld_pkg;

  // Next run length: a level change restarts it, otherwise it saturates at cap.
  function automatic int run_step(input int run, input logic moved, input int cap);
    if (moved) return 0;
    return (run >= cap) ? cap : run + 1;
  endfunction

  // Next window transition tally, saturating at cap.
  function automatic int tally_step(input int tally, input logic moved, input int cap);
    if (!moved) return tally;
    return (tally >= cap) ? cap : tally + 1;
  endfunction

  // True when the tally including the current bit exceeds min_count.
  function automatic logic tally_enough(input int tally, input logic moved, input int min_count);
    return (tally + (moved ? 1 : 0)) > min_count;
  endfunction

endpackage

// File: rtl/sld_run_tracker.sv
module sld_run_tracker #(
  parameter int RUN_LIMIT = 128,
  localparam int RUN_CAP = RUN_LIMIT + 1,
  localparam int RW = $clog2(RUN_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          din,
  output logic          prev_bit,
  output logic          toggle,
  output logic          declare_hit,
  output logic [RW-1:0] run_len
);
  logic          prev_q;
  logic [RW-1:0] run_q;

  always_comb begin
    toggle      = bit_en & (din ^ prev_q);
    declare_hit = bit_en & ~(din ^ prev_q) & (int'(run_q) >= RUN_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else if (bit_en) begin
      prev_q <= din;
      run_q  <= RW'(sld_pkg::run_step(int'(run_q), din ^ prev_q, RUN_CAP));
    end
  end

  assign prev_bit = prev_q;
  assign run_len  = run_q;
endmodule

// File: rtl/sld_window.sv
module sld_window #(
  parameter int WIN_LEN = 128,
  parameter int CLR_MIN = 16,
  localparam int PW = $clog2(WIN_LEN),
  localparam int TCAP = CLR_MIN + 1,
  localparam int TW = $clog2(TCAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic toggle,
  output logic window_end,
  output logic clear_hit
);
  logic [PW-1:0] pos_q;
  logic [TW-1:0] tally_q;

  always_comb begin
    window_end = bit_en & (pos_q == PW'(WIN_LEN - 1));
    clear_hit  = window_end & sld_pkg::tally_enough(int'(tally_q), toggle, CLR_MIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      tally_q <= '0;
    end else if (bit_en) begin
      if (pos_q == PW'(WIN_LEN - 1)) begin
        pos_q   <= '0;
        tally_q <= '0;
      end else begin
        pos_q   <= pos_q + 1'b1;
        tally_q <= TW'(sld_pkg::tally_step(int'(tally_q), toggle, TCAP));
      end
    end
  end
endmodule

// File: rtl/sld_alarm.sv
module sld_alarm (
  input  logic clk,
  input  logic rst,
  input  logic det_en_n,
  input  logic ext_a,
  input  logic ext_b,
  input  logic declare_hit,
  input  logic clear_hit,
  input  logic prev_bit,
  output logic los,
  output logic dout
);
  logic ext_force;
  logic alarm_q, alarm_d, los_q;

  always_comb begin
    ext_force = ~(ext_a ^ ext_b);
    alarm_d   = alarm_q;
    if (det_en_n)         alarm_d = 1'b0;
    else if (declare_hit) alarm_d = 1'b1;
    else if (clear_hit)   alarm_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b1;
      los_q   <= 1'b1;
    end else begin
      alarm_q <= alarm_d;
      los_q   <= alarm_d | ext_force;
    end
  end

  assign los  = los_q;
  assign dout = prev_bit & ~los_q;
endmodule

// File: rtl/sig_loss_monitor.sv
module sig_loss_monitor #(
  parameter int RUN_LIMIT = 128,
  parameter int WIN_LEN = 128,
  parameter int CLR_MIN = 16,
  localparam int RW = $clog2(RUN_LIMIT + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic din,
  input  logic det_en_n,
  input  logic ext_a,
  input  logic ext_b,
  output logic los,
  output logic dout
);
  logic          prev_bit;
  logic          toggle;
  logic          declare_hit;
  logic          window_end;
  logic          clear_hit;
  logic [RW-1:0] run_len;

  sld_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din),
    .prev_bit(prev_bit), .toggle(toggle), .declare_hit(declare_hit), .run_len(run_len)
  );

  sld_window #(.WIN_LEN(WIN_LEN), .CLR_MIN(CLR_MIN)) u_win (
    .clk(clk), .rst(rst), .bit_en(bit_en), .toggle(toggle),
    .window_end(window_end), .clear_hit(clear_hit)
  );

  sld_alarm u_alarm (
    .clk(clk), .rst(rst), .det_en_n(det_en_n), .ext_a(ext_a), .ext_b(ext_b),
    .declare_hit(declare_hit), .clear_hit(clear_hit), .prev_bit(prev_bit),
    .los(los), .dout(dout)
  );
endmodule

// File: rtl/sld_checker.sv
module sld_checker #(
  parameter int RUN_LIMIT = 128,
  localparam int RW = $clog2(RUN_LIMIT + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          det_en_n,
  input logic          ext_a,
  input logic          ext_b,
  input logic          los,
  input logic          dout,
  input logic          toggle,
  input logic          declare_hit,
  input logic          window_end,
  input logic          clear_hit,
  input logic [RW-1:0] run_len
);
  a_r1_declare_sets: assert property (@(posedge clk) disable iff (rst)
    declare_hit && !det_en_n |=> los);

  a_r2_toggle_restarts: assert property (@(posedge clk) disable iff (rst)
    toggle |=> run_len == '0);

  a_r2_run_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(run_len) <= RUN_LIMIT + 1);

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clear_hit && (ext_a != ext_b) |=> !los);

  a_r5_forced_zero: assert property (@(posedge clk) disable iff (rst)
    los |-> !dout);

  a_r6_ext_forces: assert property (@(posedge clk) disable iff (rst)
    (ext_a == ext_b) |=> los);

  a_r7_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    det_en_n && (ext_a != ext_b) |=> !los);

  a_r8_reset_alarm: assert property (@(posedge clk)
    rst |=> los);

  a_r9_idle_no_events: assert property (@(posedge clk) disable iff (rst)
    !bit_en |-> !toggle && !window_end && !declare_hit);
endmodule

bind sig_loss_monitor sld_checker #(.RUN_LIMIT(RUN_LIMIT)) u_sld_checker (
  .clk(clk), .rst(rst), .bit_en(bit_en), .det_en_n(det_en_n),
  .ext_a(ext_a), .ext_b(ext_b), .los(los), .dout(dout),
  .toggle(toggle), .declare_hit(declare_hit), .window_end(window_end),
  .clear_hit(clear_hit), .run_len(run_len)
);

// File: tb/test_sig_loss_monitor.sv
`timescale 1ns/1ps
module test_sig_loss_monitor;
  logic clk = 1'b0, rst = 1'b1, bit_en = 1'b0, din = 1'b0;
  logic det_en_n = 1'b0, ext_a = 1'b0, ext_b = 1'b1;
  logic los, dout;

  always #2 clk = ~clk;

  sig_loss_monitor i_sig_loss_monitor (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din), .det_en_n(det_en_n),
    .ext_a(ext_a), .ext_b(ext_b), .los(los), .dout(dout)
  );

  int errs = 0, checks = 0;
  string cur_req = "R8";
  bit done = 1'b0;

  // reference model state
  logic m_prev, m_alarm, m_los;
  int m_same, m_pos, m_cnt;
  logic m_t, m_dec, m_clr;

  function automatic bit f_run_declares(int same_bits);
    return same_bits > 128;
  endfunction

  function automatic bit f_window_clears(int seen);
    return seen > 16;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev = 1'b0; m_same = 0; m_pos = 0; m_cnt = 0;
      m_alarm = 1'b1; m_los = 1'b1;
    end else begin
      m_dec = 1'b0; m_clr = 1'b0;
      if (bit_en) begin
        m_t = (din != m_prev);
        if (m_t) m_same = 0; else if (m_same < 1000) m_same = m_same + 1;
        m_dec = !m_t && f_run_declares(m_same);
        m_cnt = m_cnt + int'(m_t);
        if (m_pos == 127) begin
          m_clr = f_window_clears(m_cnt); m_cnt = 0; m_pos = 0;
        end else m_pos = m_pos + 1;
        m_prev = din;
      end
      if (det_en_n) m_alarm = 1'b0;
      else if (m_dec) m_alarm = 1'b1;
      else if (m_clr) m_alarm = 1'b0;
      m_los = m_alarm | (ext_a == ext_b);
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic e, input logic d);
    @(negedge clk);
    check(cur_req, "los model", los, m_los);
    check(cur_req, "dout model", dout, m_prev & ~m_los);
    bit_en = e;
    din = d;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // R8 reset state
    cur_req = "R8";
    repeat (3) cyc(1'b0, 1'b0);
    check("R8", "los after reset", los, 1'b1);
    check("R8", "dout after reset", dout, 1'b0);
    rst = 1'b0;

    // R3 full toggling window clears
    cur_req = "R3";
    for (int i = 0; i < 128; i++) begin
      cyc(1'b1, ~i[0]);
      if (i == 100) check("R3", "alarm held mid window", los, 1'b1);
    end
    cyc(1'b0, din);
    check("R3", "clear after 128 transitions", los, 1'b0);

    // R2 128 equal bits then a transition: no declare
    cur_req = "R2";
    for (int i = 0; i < 128; i++) cyc(1'b1, din);
    cyc(1'b0, din);
    check("R2", "128 equal bits", los, 1'b0);
    cyc(1'b1, ~din);
    for (int i = 0; i < 128; i++) cyc(1'b1, din);
    cyc(1'b0, din);
    check("R2", "restart after transition", los, 1'b0);
    // R1 129th equal bit declares
    cur_req = "R1";
    cyc(1'b1, din);
    cyc(1'b0, din);
    check("R1", "declare on 129th equal bit", los, 1'b1);
    check("R5", "dout forced during alarm", dout, 1'b0);

    // R3 16 transitions not enough, 17 enough
    cur_req = "R3";
    while (m_pos != 0) cyc(1'b1, din);
    for (int i = 0; i < 128; i++) cyc(1'b1, (i < 16) ? ~din : din);
    cyc(1'b0, din);
    check("R3", "16 transitions keep alarm", los, 1'b1);
    while (m_pos != 0) cyc(1'b1, din);
    for (int i = 0; i < 128; i++) cyc(1'b1, (i < 17) ? ~din : din);
    cyc(1'b0, din);
    check("R3", "17 transitions clear", los, 1'b0);

    // R4 transitions split across a boundary
    cur_req = "R4";
    for (int i = 0; i < 130; i++) cyc(1'b1, din);
    cyc(1'b0, din);
    check("R1", "redeclare", los, 1'b1);
    while (m_pos != 118) cyc(1'b1, din);
    for (int i = 0; i < 20; i++) cyc(1'b1, ~din);
    for (int i = 0; i < 118; i++) cyc(1'b1, din);
    cyc(1'b0, din);
    check("R4", "no carry across windows", los, 1'b1);

    // R6 force together with a window-end clear
    cur_req = "R6";
    while (m_pos != 0) cyc(1'b1, din);
    for (int i = 0; i < 128; i++) begin
      if (i == 126) ext_b = ext_a;
      cyc(1'b1, (i < 20) ? ~din : din);
    end
    cyc(1'b0, din);
    check("R6", "force wins at clear", los, 1'b1);
    ext_b = ~ext_a;
    cyc(1'b0, din);
    check("R3", "clear taken under force", los, 1'b0);
    // R5 data passes while clear
    cur_req = "R5";
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    check("R5", "dout passes last bit", dout, 1'b1);
    cur_req = "R6";
    ext_a = 1'b0; ext_b = 1'b0;
    cyc(1'b0, din);
    check("R6", "xnor low-low forces", los, 1'b1);
    check("R5", "dout zero under force", dout, 1'b0);
    ext_a = 1'b1; ext_b = 1'b0;
    cyc(1'b0, din);
    check("R6", "release force", los, 1'b0);

    // R7 detection disable
    cur_req = "R7";
    for (int i = 0; i < 130; i++) cyc(1'b1, din);
    cyc(1'b0, din);
    check("R1", "declare before disable", los, 1'b1);
    det_en_n = 1'b1;
    cyc(1'b0, din);
    check("R7", "disable clears alarm", los, 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b1, din);
    check("R7", "no declare while disabled", los, 1'b0);
    det_en_n = 1'b0;
    cyc(1'b1, din);
    cyc(1'b0, din);
    check("R7", "declare after re-enable", los, 1'b1);

    // R9 idle cycles are not sampled
    cur_req = "R9";
    while (m_pos != 0) cyc(1'b1, din);
    for (int i = 0; i < 128; i++) cyc(1'b1, ~din);
    cyc(1'b0, din);
    check("R3", "clear before idle test", los, 1'b0);
    for (int i = 0; i < 400; i++) cyc(1'b0, i[0]);
    cyc(1'b0, din);
    check("R9", "idle cycles do not declare", los, 1'b0);

    // random segments
    cur_req = "R5";
    for (int s = 0; s < 80; s++) begin
      int pct;
      case ($urandom % 6)
        0: pct = 0;  1: pct = 2;  2: pct = 8;
        3: pct = 15; 4: pct = 30; default: pct = 50;
      endcase
      ext_a = 1'($urandom % 2);
      ext_b = (($urandom % 6) == 0) ? ext_a : ~ext_a;
      det_en_n = (($urandom % 8) == 0);
      for (int i = 0; i < 256; i++)
        cyc(1'(($urandom % 4) != 0), (($urandom % 100) < pct) ? ~din : din);
    end

    // R8 reset mid-run
    cur_req = "R8";
    rst = 1'b1;
    cyc(1'b0, din);
    cyc(1'b0, din);
    check("R8", "los after mid-run reset", los, 1'b1);
    check("R8", "dout after mid-run reset", dout, 1'b0);
    rst = 1'b0;
    cyc(1'b0, din);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule